// File: doc/BRIEF.md
# Banked-Mask Vectored Interrupt Controller

This block collects a set of level-sensitive interrupt lines (128 by default) and raises one interrupt request towards a processor. Every line has a mask bit and a software-forced pending bit. Both are kept in 32-bit banks that are written only through paired write-one-to-set and write-one-to-clear registers, so software never needs a read-modify-write to change one source. A source is live when its input line or its software bit is high and its mask bit is clear.

When the request is idle and at least one source is live, the controller latches the lowest-numbered live source and raises its request output. The latched number stays frozen, and the request stays high, until software writes an acknowledge. Software reads the latched number from an active-source register. That read carries a spurious marker in the upper bits when nothing is latched, or when the latched source has since gone quiet.

A 32-bit register port also provides a revision value, a soft reset with a completion flag, and a threshold register. A threshold of zero stops new selections, and any nonzero value lets them through.

Top module: `birq_ctrl`

## Requirements
- R1: After the reset input is released, every source is masked, every software-pending bit is clear, `irq_out` is low, the threshold reads 0xFF and the status register (offset 0x14) reads 1 in bit 0.
- R2: For bank n (source i is in bank i>>5 at bit i&31), writing to offset 0x88+0x20·n unmasks each source whose data bit is 1, and writing to offset 0x8C+0x20·n masks each such source. Data bits that are 0 leave the mask unchanged.
- R3: For bank n, writing to offset 0x90+0x20·n sets the software-pending bit of each source whose data bit is 1, and writing to 0x94+0x20·n clears it. A software-pending bit makes an unmasked source live in the same way as its input line.
- R4: When nothing is latched and the threshold is nonzero, the lowest-numbered live source is latched on the next clock edge, and `irq_out` goes high from that edge.
- R5: While a source is latched, `irq_out` and the latched number stay unchanged until a write to offset 0x48 with data bit 0 set. A write there with bit 0 clear has no effect. After an acknowledge, `irq_out` is low for at least one cycle before the next selection.
- R6: A read of offset 0x40 returns the latched number in bits 6:0. Bits 31:7 read all ones when nothing is latched or when the latched source is no longer live, and read zero otherwise.
- R7: A write to offset 0x10 with data bit 1 set masks all sources, clears all software-pending bits, drops the latch and `irq_out`, restores the threshold to 0xFF, and clears status bit 0. That bit reads 1 again after exactly 4 clock edges.
- R8: Offset 0x68 holds an 8-bit threshold that can be read and written. While it is 0, no new source is latched.
- R9: Offset 0x00 reads the revision, with the major number in bits 7:4 and the minor number in bits 3:0 (default 2.1). Reads of any other offset that is not listed above, including the bank registers, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Level-sensitive interrupt lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` is zero when low |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Register read data, combinational from `addr` |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The embedded properties watch invariants on every cycle: a latched source stays frozen until an acknowledge or a soft reset, a selection always names a live source and is latched on the following edge, a zero threshold keeps the request low, each mask or software-pending write takes effect on the bits it names, and a soft reset leaves every bank masked and cleared. What only the bench scenarios can show is the visible outcome at the register port. That covers which source wins among specific pairs across bank boundaries, the exact spurious encoding after a line drops, the fact that a write with the acknowledge bit clear does nothing, the exact four-edge timing of the completion flag, and the read values for the revision and unmapped offsets.

// File: rtl/birq_pkg.sv
package birq_pkg;
    // Register byte offsets
    localparam int OFS_REV      = 'h00;
    localparam int OFS_SYSCFG   = 'h10;
    localparam int OFS_SYSSTAT  = 'h14;
    localparam int OFS_ACTIVE   = 'h40;
    localparam int OFS_CTRL     = 'h48;
    localparam int OFS_THRESH   = 'h68;
    localparam int OFS_BANK0    = 'h88;
    localparam int BANK_STRIDE  = 'h20;
    // Offsets inside one bank window
    localparam int BK_UNMASK    = 'h0;
    localparam int BK_MASK      = 'h4;
    localparam int BK_SWSET     = 'h8;
    localparam int BK_SWCLR     = 'hC;
    // Control bits
    localparam int SYSCFG_RST_BIT = 1;
    localparam int CTRL_ACK_BIT   = 0;
endpackage

// File: rtl/birq_bank.sv
module birq_bank #(
    parameter int BANK_W = 32,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] mask_q,
    output logic [BANK_W-1:0] swp_q
);
    import birq_pkg::*;

    localparam logic [ADDR_W-1:0] A_UNMASK = ADDR_W'(BASE + BK_UNMASK);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(BASE + BK_MASK);
    localparam logic [ADDR_W-1:0] A_SWSET  = ADDR_W'(BASE + BK_SWSET);
    localparam logic [ADDR_W-1:0] A_SWCLR  = ADDR_W'(BASE + BK_SWCLR);

    typedef struct packed {
        logic [BANK_W-1:0] mask;
        logic [BANK_W-1:0] swp;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (soft_clr) begin
            st_d.mask = '1;
            st_d.swp  = '0;
        end else if (wr_en) begin
            if (addr == A_UNMASK) st_d.mask = st_q.mask & ~wdata;
            if (addr == A_MASK)   st_d.mask = st_q.mask | wdata;
            if (addr == A_SWSET)  st_d.swp  = st_q.swp | wdata;
            if (addr == A_SWCLR)  st_d.swp  = st_q.swp & ~wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= '1;
            st_q.swp  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q = st_q.mask;
    assign swp_q  = st_q.swp;

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_MASK && !soft_clr) |=> ((mask_q & $past(wdata)) == $past(wdata))); // R2
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_UNMASK && !soft_clr) |=> ((mask_q & $past(wdata)) == '0)); // R2
    AST_SW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SWCLR && !soft_clr) |=> ((swp_q & $past(wdata)) == '0)); // R3
    AST_SOFT_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (mask_q == '1 && swp_q == '0)); // R7
endmodule

// File: rtl/birq_pick.sv
module birq_pick #(
    parameter int N    = 128,
    parameter int ID_W = $clog2(N)
) (
    input  logic [N-1:0]    req,
    output logic            valid,
    output logic [ID_W-1:0] id
);
    always_comb begin
        valid = |req;
        id    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) id = ID_W'(i);
        end
    end
endmodule

// File: rtl/birq_ctrl.sv
module birq_ctrl #(
    parameter int          NUM_SRC  = 128,
    parameter int          DATA_W   = 32,
    parameter int          ADDR_W   = 8,
    parameter int          BANK_W   = 32,
    parameter int          SRST_CYC = 4,
    parameter logic [7:0]  REV      = 8'h21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq_out
);
    import birq_pkg::*;

    localparam int NUM_BANK = NUM_SRC / BANK_W;
    localparam int ID_W     = $clog2(NUM_SRC);
    localparam int CNT_W    = $clog2(SRST_CYC + 1);

    localparam logic [ADDR_W-1:0] A_REV     = ADDR_W'(OFS_REV);
    localparam logic [ADDR_W-1:0] A_SYSCFG  = ADDR_W'(OFS_SYSCFG);
    localparam logic [ADDR_W-1:0] A_SYSSTAT = ADDR_W'(OFS_SYSSTAT);
    localparam logic [ADDR_W-1:0] A_ACTIVE  = ADDR_W'(OFS_ACTIVE);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_THRESH  = ADDR_W'(OFS_THRESH);

    typedef struct packed {
        logic            hold;
        logic [ID_W-1:0] id;
        logic [CNT_W-1:0] cnt;
        logic            done;
        logic [7:0]      thr;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic [NUM_SRC-1:0] mask_all, swp_all, live;
    logic               pk_valid;
    logic [ID_W-1:0]    pk_id;
    logic               soft_req, ack, thr_wr, spur;

    for (genvar g = 0; g < NUM_BANK; g++) begin : g_bank
        birq_bank #(
            .BANK_W (BANK_W),
            .ADDR_W (ADDR_W),
            .BASE   (ADDR_W'(OFS_BANK0 + g * BANK_STRIDE))
        ) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_clr (soft_req),
            .wr_en    (wr_en),
            .addr     (addr),
            .wdata    (wdata[BANK_W-1:0]),
            .mask_q   (mask_all[g*BANK_W +: BANK_W]),
            .swp_q    (swp_all[g*BANK_W +: BANK_W])
        );
    end

    assign live = (src_in | swp_all) & ~mask_all;

    birq_pick #(.N(NUM_SRC), .ID_W(ID_W)) pick_i (
        .req   (live),
        .valid (pk_valid),
        .id    (pk_id)
    );

    assign soft_req = wr_en && (addr == A_SYSCFG) && wdata[SYSCFG_RST_BIT];
    assign ack      = wr_en && (addr == A_CTRL) && wdata[CTRL_ACK_BIT];
    assign thr_wr   = wr_en && (addr == A_THRESH);

    always_comb begin
        st_d = st_q;
        if (soft_req) begin
            st_d.hold = 1'b0;
            st_d.id   = '0;
            st_d.thr  = 8'hFF;
            st_d.cnt  = CNT_W'(SRST_CYC);
            st_d.done = 1'b0;
        end else begin
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
                if (st_q.cnt == CNT_W'(1)) st_d.done = 1'b1;
            end
            if (thr_wr) st_d.thr = wdata[7:0];
            if (ack) begin
                st_d.hold = 1'b0;
            end else if (!st_q.hold && pk_valid && st_q.thr != 8'h00) begin
                st_d.hold = 1'b1;
                st_d.id   = pk_id;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hold <= 1'b0;
            st_q.id   <= '0;
            st_q.cnt  <= '0;
            st_q.done <= 1'b1;
            st_q.thr  <= 8'hFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_out = st_q.hold;
    assign spur    = !st_q.hold || !live[st_q.id];

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_REV:     rdata = DATA_W'(REV);
                A_SYSSTAT: rdata = DATA_W'(st_q.done);
                A_ACTIVE:  rdata = {{(DATA_W-ID_W){spur}}, st_q.id};
                A_THRESH:  rdata = DATA_W'(st_q.thr);
                default:   rdata = '0;
            endcase
        end
    end

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !ack && !soft_req) |=> (irq_out && $stable(st_q.id))); // R5
    AST_PICK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pk_valid |-> live[pk_id]); // R4
    AST_PICK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && pk_valid && st_q.thr != 8'h00 && !ack && !soft_req)
            |=> (irq_out && st_q.id == $past(pk_id))); // R4
    AST_THR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && st_q.thr == 8'h00 && !soft_req) |=> !irq_out); // R8
    AST_SOFT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        soft_req |=> (!irq_out && !st_q.done)); // R7
endmodule

// File: tb/birq_ctrl_tb_top.sv
`timescale 1ns/1ps
module birq_ctrl_tb_top;
    localparam int NS = 128;
    localparam logic [7:0] O_REV = 8'h00, O_CFG = 8'h10, O_STAT = 8'h14,
                           O_ACT = 8'h40, O_CTL = 8'h48, O_THR = 8'h68;
    localparam logic [31:0] SPUR = 32'hFFFF_FF80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_in = '0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq_out;
    int            checks = 0, errors = 0;
    logic [31:0]   rv;

    always #2 clk = ~clk;

    birq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    // {source a, source b, expected winner}
    localparam logic [20:0] VEC [8] = '{
        {7'd5,   7'd90,  7'd5},
        {7'd127, 7'd64,  7'd64},
        {7'd31,  7'd32,  7'd31},
        {7'd0,   7'd127, 7'd0},
        {7'd100, 7'd100, 7'd100},
        {7'd63,  7'd95,  7'd63},
        {7'd96,  7'd127, 7'd96},
        {7'd33,  7'd34,  7'd33}
    };

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog got=hung exp=done");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 irq low", 32'(irq_out), 32'd0);
        rd(O_STAT, rv); chk("R1 done flag", rv, 32'd1);
        rd(O_THR, rv);  chk("R1 threshold", rv, 32'hFF);
        // R9 revision and unmapped
        rd(O_REV, rv);  chk("R9 revision", rv, 32'h21);
        rd(8'h04, rv);  chk("R9 unmapped", rv, 32'd0);
        rd(8'h88, rv);  chk("R9 bank read", rv, 32'd0);
        rd(O_ACT, rv);  chk("R6 idle spurious", rv, SPUR);
        src_in = '1;
        repeat (3) tick();
        chk("R1 all masked", 32'(irq_out), 32'd0);
        src_in = '0;

        // unmask everything
        for (int b = 0; b < 4; b++) wr(8'(8'h88 + 8'h20 * b), 32'hFFFF_FFFF);

        // vector table: R4 lowest wins, R6 active number and spurious
        for (int v = 0; v < 8; v++) begin
            src_in = '0;
            src_in[VEC[v][20:14]] = 1'b1;
            src_in[VEC[v][13:7]]  = 1'b1;
            tick();
            chk($sformatf("R4 irq vec%0d", v), 32'(irq_out), 32'd1);
            rd(O_ACT, rv); chk($sformatf("R4 winner vec%0d", v), rv, 32'(VEC[v][6:0]));
            src_in = '0;
            rd(O_ACT, rv); chk($sformatf("R6 dropped vec%0d", v), rv, SPUR | 32'(VEC[v][6:0]));
            wr(O_CTL, 32'd1);
            tick();
            chk($sformatf("R5 idle after ack vec%0d", v), 32'(irq_out), 32'd0);
        end

        // R2 mask set on source 40, zero bits keep source 2 unmasked
        wr(8'hAC, 32'h0000_0100);
        wr(8'h8C, 32'h0000_0002);
        src_in[40] = 1'b1;
        repeat (2) tick();
        chk("R2 masked src40", 32'(irq_out), 32'd0);
        src_in[2] = 1'b1;
        tick();
        rd(O_ACT, rv); chk("R2 zero bits keep src2", rv, 32'd2);
        src_in[2] = 1'b0;
        wr(O_CTL, 32'd1);
        wr(8'hA8, 32'h0000_0100);
        tick();
        rd(O_ACT, rv); chk("R2 unmasked src40", rv, 32'd40);
        src_in = '0;
        wr(O_CTL, 32'd1);
        tick();

        // R3 software pending on source 99
        wr(8'hF0, 32'h0000_0008);
        tick();
        chk("R3 sw irq", 32'(irq_out), 32'd1);
        rd(O_ACT, rv); chk("R3 sw id", rv, 32'd99);
        wr(8'hF4, 32'h0000_0008);
        rd(O_ACT, rv); chk("R3 sw cleared", rv, SPUR | 32'd99);
        wr(O_CTL, 32'd1);
        tick();
        chk("R3 quiet", 32'(irq_out), 32'd0);

        // R5 hold and acknowledge
        src_in[7] = 1'b1;
        tick();
        wr(O_CTL, 32'd2);
        chk("R5 bit0 clear no ack", 32'(irq_out), 32'd1);
        src_in[3] = 1'b1;
        tick();
        rd(O_ACT, rv); chk("R5 frozen id", rv, 32'd7);
        wr(O_CTL, 32'd1);
        chk("R5 ack drops irq", 32'(irq_out), 32'd0);
        tick();
        rd(O_ACT, rv); chk("R5 reselect lower", rv, 32'd3);
        src_in = '0;
        wr(O_CTL, 32'd1);
        tick();

        // R8 threshold
        wr(O_THR, 32'd0);
        src_in[10] = 1'b1;
        repeat (3) tick();
        chk("R8 blocked", 32'(irq_out), 32'd0);
        rd(O_THR, rv); chk("R8 readback", rv, 32'd0);
        wr(O_THR, 32'hFF);
        tick();
        chk("R8 released", 32'(irq_out), 32'd1);
        src_in = '0;
        wr(O_CTL, 32'd1);

        // R7 soft reset
        src_in[12] = 1'b1;
        tick();
        chk("R7 pre irq", 32'(irq_out), 32'd1);
        wr(O_THR, 32'h05);
        wr(O_CFG, 32'd2);
        chk("R7 irq dropped", 32'(irq_out), 32'd0);
        rd(O_STAT, rv); chk("R7 busy", rv, 32'd0);
        repeat (3) tick();
        rd(O_STAT, rv); chk("R7 busy at 3", rv, 32'd0);
        tick();
        rd(O_STAT, rv); chk("R7 done at 4", rv, 32'd1);
        chk("R7 masked after", 32'(irq_out), 32'd0);
        rd(O_THR, rv); chk("R7 threshold restored", rv, 32'hFF);
        src_in = '0;

        finish_run();
    end
endmodule